// File: doc/BRIEF.md
# Frame-Strobed Configuration Latch Array

This block stores the configuration bits of one fabric tile. Frames are written one at a time. A loader presents a word that is one frame wide on `frame_data` and raises the matching bit of the one-hot `frame_strobe` vector. Each frame position that carries a configuration bit has one level-sensitive storage cell. That cell follows its data bit while the frame strobe is high and keeps the value once the strobe falls. Positions that carry no configuration bit have no cell. Every stored bit is presented twice: once true on `cfg_q` and once inverted on `cfg_qn`.

Configuration bits fill the frames from the top down. The highest configuration bit sits in frame 0 at its most significant position. The order descends through frame 0 and then continues at the top position of frame 1, and so on, so only the last used frame can be partly filled. The frame width, the frame count and the number of configuration bits are parameters, and elaboration stops if the bits do not fit. Setting the `EMULATE` parameter changes the storage variant. The cells are then replaced by a constant flat `BITSTREAM` parameter, so a model can start already configured without driving any frames.

Top module: `cfg_latch_array`

## Requirements
- R1: Configuration bit k (0 ≤ k < CFG_BITS) is stored in frame f = (CFG_BITS-1-k) / FRAME_W at position p = FRAME_W-1-((CFG_BITS-1-k) mod FRAME_W) of `frame_data`. Configuration bit CFG_BITS-1 therefore sits at frame 0, position FRAME_W-1.
- R2: When `EMULATE`=0, `cfg_qn` is always the bitwise inverse of `cfg_q`.
- R3: When no strobe bit is high, `cfg_q` holds its value whatever `frame_data` does.
- R4: While `frame_strobe[f]` is high, the bits mapped to frame f follow `frame_data` with no clock involved.
- R5: Data on frame positions that carry no configuration bit has no effect on any output.
- R6: When several strobe bits are high at once, every selected frame captures the same data word.
- R7: When `EMULATE`=1, `cfg_q[k]` equals `BITSTREAM[f*FRAME_W + p]`, with f and p taken from R1. In this mode `frame_data` and `frame_strobe` have no effect.
- R8: When `EMULATE`=1, `cfg_qn` is the bitwise inverse of `cfg_q`.
- R9: A strobe on frame f changes only the configuration bits mapped to frame f. All other bits keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| frame_data | input | FRAME_W | Data word for the frame being written |
| frame_strobe | input | FRAMES | Frame select; bit f high makes frame f transparent |
| cfg_q | output | CFG_BITS | Stored configuration bits, true polarity |
| cfg_qn | output | CFG_BITS | Stored configuration bits, inverted |

## Verification
A mapping error would put a loaded bit on the wrong configuration output. This shows up as soon as any frame becomes transparent, because the bench checks every bit of the selected frame while its strobe is high, against a model of the descending order. A cell that fails to hold, or that sits on the wrong strobe, changes other outputs during a later write or during data changes with all strobes low. The full vector is compared after each such step, so the error appears at the next sample. Emulation outputs are constant and are compared against the flat parameter at the start and again after all the latch traffic.

// File: rtl/cfg_latch_pkg.sv
`timescale 1ns/1ps
package cfg_latch_pkg;

   // Configuration bit index held at frame f, position p; negative when the
   // position carries no configuration bit. Filling is top-down: frame 0,
   // position w-1 holds bit n-1.
   function automatic int cfg_index(input int f, input int p,
                                    input int w, input int n);
      return n - 1 - (f * w + (w - 1 - p));
   endfunction

   // Number of positions in frame f that carry a configuration bit.
   function automatic int frame_used(input int f, input int w, input int n);
      int cnt;
      cnt = 0;
      for (int p = 0; p < w; p++)
         if (cfg_index(f, p, w, n) >= 0) cnt++;
      return cnt;
   endfunction

   // Sum of used positions over all frames.
   function automatic int total_used(input int frames, input int w, input int n);
      int cnt;
      cnt = 0;
      for (int f = 0; f < frames; f++)
         cnt += frame_used(f, w, n);
      return cnt;
   endfunction

endpackage

// File: rtl/cfg_latch_cell.sv
`timescale 1ns/1ps
module cfg_latch_cell (
   input  logic d,
   input  logic en,
   output logic q,
   output logic qn
);

   logic store_r;

   // Transparent while en is high, holds while low.
   always_latch begin
      if (en) store_r <= d;
   end

   assign q  = store_r;
   assign qn = ~store_r;

endmodule

// File: rtl/cfg_frame_slice.sv
`timescale 1ns/1ps
module cfg_frame_slice
   import cfg_latch_pkg::*;
#(
   parameter int           FRAME_W   = 32,
   parameter int           CFG_BITS  = 600,
   parameter int           FRAME_IDX = 0,
   parameter bit           EMULATE   = 1'b0,
   parameter logic [FRAME_W-1:0] BS_SLICE = '0
) (
   input  logic [FRAME_W-1:0] data,
   input  logic               strobe,
   output logic [FRAME_W-1:0] q,
   output logic [FRAME_W-1:0] qn
);

   // Not every position or the strobe is read in every variant.
   logic unused_in;
   assign unused_in = ^{data, strobe};

   for (genvar p = 0; p < FRAME_W; p++) begin : g_pos
      localparam int IDX = cfg_index(FRAME_IDX, p, FRAME_W, CFG_BITS);
      if (IDX < 0) begin : g_empty
         // No storage: the data bit at this position is ignored.
         assign q[p]  = 1'b0;
         assign qn[p] = 1'b1;
      end else if (EMULATE) begin : g_const
         assign q[p]  = BS_SLICE[p];
         assign qn[p] = ~BS_SLICE[p];
      end else begin : g_cell
         cfg_latch_cell u_cell (
            .d  (data[p]),
            .en (strobe),
            .q  (q[p]),
            .qn (qn[p])
         );
      end
   end

endmodule

// File: rtl/cfg_latch_array.sv
`timescale 1ns/1ps
module cfg_latch_array
   import cfg_latch_pkg::*;
#(
   parameter int FRAME_W  = 32,
   parameter int FRAMES   = 20,
   parameter int CFG_BITS = 600,
   parameter bit EMULATE  = 1'b0,
   parameter logic [FRAME_W*FRAMES-1:0] BITSTREAM = '0
) (
   input  logic [FRAME_W-1:0]  frame_data,
   input  logic [FRAMES-1:0]   frame_strobe,
   output logic [CFG_BITS-1:0] cfg_q,
   output logic [CFG_BITS-1:0] cfg_qn
);

   localparam int CAPACITY = FRAME_W * FRAMES;
   localparam int USED     = total_used(FRAMES, FRAME_W, CFG_BITS);

   // Elaboration-time parameter checks.
   if (FRAME_W < 1) begin : g_chk_w
      $error("cfg_latch_array: FRAME_W must be at least 1");
   end
   if (FRAMES < 1) begin : g_chk_f
      $error("cfg_latch_array: FRAMES must be at least 1");
   end
   if (CFG_BITS < 1) begin : g_chk_n
      $error("cfg_latch_array: CFG_BITS must be at least 1");
   end
   if (CFG_BITS > CAPACITY) begin : g_chk_cap
      $error("cfg_latch_array: CFG_BITS exceeds FRAME_W*FRAMES");
   end
   if (USED != CFG_BITS) begin : g_chk_used
      $error("cfg_latch_array: mapped positions differ from CFG_BITS");
   end

   logic [FRAMES-1:0][FRAME_W-1:0] frm_q;
   logic [FRAMES-1:0][FRAME_W-1:0] frm_qn;

   // Empty positions of the frame outputs are not gathered.
   logic unused_frm;
   assign unused_frm = ^{frm_q, frm_qn};

   for (genvar f = 0; f < FRAMES; f++) begin : g_frame
      cfg_frame_slice #(
         .FRAME_W   (FRAME_W),
         .CFG_BITS  (CFG_BITS),
         .FRAME_IDX (f),
         .EMULATE   (EMULATE),
         .BS_SLICE  (BITSTREAM[f*FRAME_W +: FRAME_W])
      ) u_slice (
         .data   (frame_data),
         .strobe (frame_strobe[f]),
         .q      (frm_q[f]),
         .qn     (frm_qn[f])
      );

      for (genvar p = 0; p < FRAME_W; p++) begin : g_map
         localparam int IDX = cfg_index(f, p, FRAME_W, CFG_BITS);
         if (IDX >= 0) begin : g_used
            assign cfg_q[IDX]  = frm_q[f][p];
            assign cfg_qn[IDX] = frm_qn[f][p];
         end
      end
   end

endmodule

// File: rtl/cfg_latch_array_chk.sv
`timescale 1ns/1ps
module cfg_latch_array_chk #(
   parameter int FRAME_W  = 32,
   parameter int FRAMES   = 20,
   parameter int CFG_BITS = 600,
   parameter bit EMULATE  = 1'b0,
   parameter logic [FRAME_W*FRAMES-1:0] BITSTREAM = '0
) (
   input logic [FRAME_W-1:0]  frame_data,
   input logic [FRAMES-1:0]   frame_strobe,
   input logic [CFG_BITS-1:0] cfg_q,
   input logic [CFG_BITS-1:0] cfg_qn
);

   // Inverse view of the mapping: from a bit index back to frame and position.
   function automatic int frm_of(input int k);
      return (CFG_BITS - 1 - k) / FRAME_W;
   endfunction

   function automatic int pos_of(input int k);
      return FRAME_W - 1 - ((CFG_BITS - 1 - k) % FRAME_W);
   endfunction

   always_comb begin
      AST_STROBE_KNOWN: assert (!$isunknown(frame_strobe))
         else $error("frame strobe unknown"); // R4
      for (int k = 0; k < CFG_BITS; k++) begin
         if (!$isunknown(cfg_q[k])) begin
            AST_QN_INVERSE: assert (cfg_qn[k] == ~cfg_q[k])
               else $error("cfg_qn[%0d] not inverse", k); // R2
         end
         if (!EMULATE && frame_strobe[frm_of(k)] === 1'b1 &&
             !$isunknown(frame_data[pos_of(k)])) begin
            AST_TRANSPARENT: assert (cfg_q[k] == frame_data[pos_of(k)])
               else $error("cfg_q[%0d] not following frame data", k); // R4
         end
         if (EMULATE) begin
            AST_EMU_MAP: assert (cfg_q[k] === BITSTREAM[frm_of(k)*FRAME_W + pos_of(k)])
               else $error("cfg_q[%0d] differs from bitstream", k); // R7
         end
      end
   end

endmodule

bind cfg_latch_array cfg_latch_array_chk #(
   .FRAME_W   (FRAME_W),
   .FRAMES    (FRAMES),
   .CFG_BITS  (CFG_BITS),
   .EMULATE   (EMULATE),
   .BITSTREAM (BITSTREAM)
) u_chk (
   .frame_data   (frame_data),
   .frame_strobe (frame_strobe),
   .cfg_q        (cfg_q),
   .cfg_qn       (cfg_qn)
);

// File: tb/sim_cfg_latch_array.sv
`timescale 1ns/1ps
module sim_cfg_latch_array;

   localparam int W  = 8;
   localparam int F  = 5;
   localparam int N  = 35;
   localparam logic [W*F-1:0] BS = 40'h96_E1_3C_A5_0F;

   logic         clk = 1'b0;
   logic [W-1:0] frame_data = '0;
   logic [F-1:0] frame_strobe = '0;
   logic [N-1:0] q0, qn0, q1, qn1;

   int total = 0;
   int fails = 0;

   logic [W-1:0] mem [F];

   always #2.5 clk = ~clk;

   cfg_latch_array #(.FRAME_W(W), .FRAMES(F), .CFG_BITS(N), .EMULATE(1'b0))
   u0 (.frame_data(frame_data), .frame_strobe(frame_strobe), .cfg_q(q0), .cfg_qn(qn0));

   cfg_latch_array #(.FRAME_W(W), .FRAMES(F), .CFG_BITS(N), .EMULATE(1'b1), .BITSTREAM(BS))
   u1 (.frame_data(frame_data), .frame_strobe(frame_strobe), .cfg_q(q1), .cfg_qn(qn1));

   function automatic int frm(input int k);
      return (N - 1 - k) / W;
   endfunction

   function automatic int pos(input int k);
      return W - 1 - ((N - 1 - k) % W);
   endfunction

   function automatic logic [N-1:0] exp_latch();
      logic [N-1:0] e;
      for (int k = 0; k < N; k++) e[k] = mem[frm(k)][pos(k)];
      return e;
   endfunction

   function automatic logic [N-1:0] exp_emu();
      logic [N-1:0] e;
      for (int k = 0; k < N; k++) e[k] = BS[frm(k)*W + pos(k)];
      return e;
   endfunction

   task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Bits of frame f only, compared with the current data word.
   task automatic check_frame(input string req, input int f, input logic [W-1:0] d);
      logic [N-1:0] a, e;
      a = '0; e = '0;
      for (int k = 0; k < N; k++)
         if (frm(k) == f) begin a[k] = q0[k]; e[k] = d[pos(k)]; end
      check(req, a, e);
   endtask

   task automatic apply(input logic [W-1:0] d, input logic [F-1:0] s);
      @(negedge clk);
      frame_data   = d;
      frame_strobe = s;
      @(posedge clk);
      #1;
   endtask

   task automatic write_frame(input int f, input logic [W-1:0] d, input string req);
      apply(d, F'(1) << f);
      check_frame(req, f, d);
      mem[f] = d;
      apply($urandom, '0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [W-1:0] d;
      void'($urandom(32'd4242));
      repeat (2) @(posedge clk);
      #1;
      // Start state: emulation outputs come straight from the bitstream.
      check("R7 emu start", q1, exp_emu());
      check("R8 emu start", qn1, ~exp_emu());

      // R1: load every frame with random data.
      for (int f = 0; f < F; f++) write_frame(f, $urandom, "R4 load");
      check("R1 mapping", q0, exp_latch());
      check("R2 complement", qn0, ~exp_latch());

      // Directed: frame 0 top position is bit N-1.
      write_frame(0, 8'h80, "R4 top");
      check("R1 top bit", q0 & (N'(1) << (N-1)), N'(1) << (N-1));

      // R3: hold with strobes low while data changes.
      for (int i = 0; i < 4; i++) begin
         apply($urandom, '0);
         check("R3 hold", q0, exp_latch());
      end
      check("R2 complement after hold", qn0, ~exp_latch());

      // R4: transparency while strobe stays high.
      apply(8'h3C, 5'b00100);
      check_frame("R4 follow a", 2, 8'h3C);
      apply(8'hC3, 5'b00100);
      check_frame("R4 follow b", 2, 8'hC3);
      mem[2] = 8'hC3;
      apply(8'h00, '0);
      check("R3 hold after drop", q0, exp_latch());

      // R9: writing frame 1 leaves the others intact.
      write_frame(1, ~mem[1], "R4 frame1");
      check("R9 only frame1", q0, exp_latch());

      // R5: frame 4 uses only positions 7..5; low positions ignored.
      d = {mem[4][7:5], 5'b10101};
      apply(d, 5'b10000);
      apply({mem[4][7:5], 5'b01010}, 5'b10000);
      apply(8'hFF, '0);
      check("R5 unused positions", q0, exp_latch());
      check("R5 unused positions qn", qn0, ~exp_latch());

      // R6: two strobes at once capture the same word.
      apply(8'h5A, 5'b01010);
      mem[1] = 8'h5A; mem[3] = 8'h5A;
      apply(8'hA5, '0);
      check("R6 multi strobe", q0, exp_latch());

      // Constrained random writes.
      for (int i = 0; i < 20; i++) begin
         int f;
         f = int'($urandom % F);
         write_frame(f, $urandom, "R4 random");
         check("R1 random", q0, exp_latch());
      end

      // Corner patterns.
      for (int f = 0; f < F; f++) write_frame(f, '1, "R4 ones");
      check("R1 all ones", q0, '1);
      for (int f = 0; f < F; f++) write_frame(f, '0, "R4 zeros");
      check("R1 all zeros", q0, '0);
      check("R2 all zeros qn", qn0, '1);

      // Emulation unaffected by all the traffic.
      check("R7 emu after traffic", q1, exp_emu());
      check("R8 emu after traffic", qn1, ~exp_emu());

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule